// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel RGB TFT panel. It runs on the pixel clock. Each scan line opens with the horizontal sync pulse, then a back-porch gap, then the visible pixels, then a front-porch gap. A frame is built the same way from whole lines: the vertical sync lines come first, then the upper blank lines, then the visible lines, then the lower blank lines. All eight geometry values and both sync polarities are run-time inputs. The block samples them into a private copy only when a frame begins, so each frame keeps one timing throughout.

Besides the two syncs, the block drives a data-enable, a one-clock line-end strobe on the last visible pixel of each visible line, and the current visible column and row. It also drives a 24-bit pixel bus carrying a test pattern computed from those coordinates. Every output is registered on the same clock edge, so the syncs, data-enable, coordinates and pixel data line up at the panel.

Top module: `lcd_raster_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to the idle state on that edge: `de`=0, `line_end`=0, `pix_x`=0, `pix_y`=0, `pix_rgb`=0, `hsync`=!`cfg_hpol`, `vsync`=!`cfg_vpol`, and the settings are captured. Outputs are registered one clock behind the scan position. The first clock edge after `rst` falls presents position 0 of line 0, which is the first horizontal sync clock of the first vertical sync line.
- R2: A line lasts `cfg_hsw`+`cfg_hbp`+`cfg_xres`+`cfg_hfp` clocks. Its positions run in this order: `cfg_hsw` clocks of sync, `cfg_hbp` clocks of back porch, `cfg_xres` visible clocks, then `cfg_hfp` clocks of front porch. `cfg_hsw` and `cfg_xres` are at least 1; either porch may be 0.
- R3: A frame lasts `cfg_vsw`+`cfg_vbp`+`cfg_yres`+`cfg_vfp` lines. Its lines run in this order: `cfg_vsw` sync lines, `cfg_vbp` upper blank lines, `cfg_yres` visible lines, then `cfg_vfp` lower blank lines. `cfg_vsw` and `cfg_yres` are at least 1.
- R4: `hsync` equals `cfg_hpol` during horizontal sync clocks and !`cfg_hpol` otherwise. `vsync` equals `cfg_vpol` for every clock of the vertical sync lines and !`cfg_vpol` otherwise. A polarity value of 1 means active high.
- R5: `de` is 1 exactly when the horizontal position is visible and the line is a visible line.
- R6: While `de` is 1, `pix_x` counts 0 to `cfg_xres`-1 across the line and `pix_y` is the visible line index, 0 to `cfg_yres`-1. While `de` is 0, both are 0.
- R7: `line_end` is a one-clock pulse that appears only together with `de`, on the clock where `pix_x` = `cfg_xres`-1.
- R8: With the default pattern, `pix_rgb` is {`pix_x`[7:0], `pix_y`[7:0], `pix_x`[7:0] ^ `pix_y`[7:0]} (bits 23:16, 15:8, 7:0) while `de` is 1, and 0 while `de` is 0.
- R9: A settings change made part way through a frame has no effect until the next frame begins. The rest of the current frame keeps the old line length, frame length and polarities. The new values apply from position 0 of line 0 of the next frame.
- R10: With xres=1024, back porch 168, front porch 16 and sync 136 clocks, the `hsync` period is 1344 clocks, and `de` is low for 320 clocks of each visible line period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_xres | input | 12 | Visible pixels per line |
| cfg_hbp | input | 12 | Clocks from sync end to first visible pixel |
| cfg_hfp | input | 12 | Clocks from last visible pixel to next sync |
| cfg_hsw | input | 12 | Horizontal sync width in clocks |
| cfg_yres | input | 11 | Visible lines per frame |
| cfg_vbp | input | 11 | Blank lines after vertical sync |
| cfg_vfp | input | 11 | Blank lines before vertical sync |
| cfg_vsw | input | 11 | Vertical sync width in lines |
| cfg_hpol | input | 1 | Horizontal sync active level |
| cfg_vpol | input | 1 | Vertical sync active level |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| line_end | output | 1 | Last visible pixel strobe |
| pix_x | output | 12 | Visible column |
| pix_y | output | 11 | Visible row |
| pix_rgb | output | 24 | Pixel data |

## Verification
The bench covers these risks:
- Porches of zero, where the visible run touches the sync. An off-by-one in the region bounds would clip or stretch the visible run, and a counter that mishandles a zero-length porch would give the wrong line length.
- A settings change issued mid-frame. A design that used the live inputs would change line length or polarity at once and tear the frame.
- The full-size horizontal geometry, to catch a counter too narrow to reach 1344 or a total computed from the wrong sum.
- Blanking of the data, coordinates and strobe. A design that did not gate the pattern would leak stale pixels into the porches.
- Alignment of every output to one clock. A misaligned stage would show as data-enable one clock apart from the coordinates.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
   // Test pattern variants selectable through the PATTERN parameter
   localparam int PAT_GRADIENT = 0;
   localparam int PAT_XORPLANE = 1;

   // Level driven on a sync pin for a given activity state and polarity
   function automatic logic sync_level(input logic active, input logic pol);
      return active ? pol : ~pol;
   endfunction
endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input  logic          clk,
   input  logic          load,
   input  logic [HW-1:0] in_xres,
   input  logic [HW-1:0] in_hbp,
   input  logic [HW-1:0] in_hfp,
   input  logic [HW-1:0] in_hsw,
   input  logic [VW-1:0] in_yres,
   input  logic [VW-1:0] in_vbp,
   input  logic [VW-1:0] in_vfp,
   input  logic [VW-1:0] in_vsw,
   input  logic          in_hpol,
   input  logic          in_vpol,
   output logic [HW-1:0] sh_xres,
   output logic [HW-1:0] sh_hbp,
   output logic [HW-1:0] sh_hfp,
   output logic [HW-1:0] sh_hsw,
   output logic [VW-1:0] sh_yres,
   output logic [VW-1:0] sh_vbp,
   output logic [VW-1:0] sh_vfp,
   output logic [VW-1:0] sh_vsw,
   output logic          sh_hpol,
   output logic          sh_vpol
);
   // Settings copy held for one whole frame
   always_ff @(posedge clk) begin
      if (load) begin
         sh_xres <= in_xres;
         sh_hbp  <= in_hbp;
         sh_hfp  <= in_hfp;
         sh_hsw  <= in_hsw;
         sh_yres <= in_yres;
         sh_vbp  <= in_vbp;
         sh_vfp  <= in_vfp;
         sh_vsw  <= in_vsw;
         sh_hpol <= in_hpol;
         sh_vpol <= in_vpol;
      end
   end
endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic [W-1:0] len_sync,
   input  logic [W-1:0] len_back,
   input  logic [W-1:0] len_act,
   input  logic [W-1:0] len_front,
   output logic [W-1:0] pos,
   output logic [W-1:0] act_idx,
   output logic         at_end,
   output logic         in_sync,
   output logic         in_act
);
   // Two guard bits keep the region sums from wrapping
   localparam int EW = W + 2;

   logic [EW-1:0] pos_e, act_lo_e, act_hi_e, total_e;

   assign pos_e    = EW'(pos);
   assign act_lo_e = EW'(len_sync) + EW'(len_back);
   assign act_hi_e = act_lo_e + EW'(len_act);
   assign total_e  = act_hi_e + EW'(len_front);

   assign at_end  = (pos_e == total_e - EW'(1));
   assign in_sync = (pos_e < EW'(len_sync));
   assign in_act  = (pos_e >= act_lo_e) && (pos_e < act_hi_e);
   assign act_idx = pos - len_sync - len_back;

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (adv)
         pos <= at_end ? '0 : pos + W'(1);
   end
endmodule

// File: rtl/lcd_pattern_gen.sv
module lcd_pattern_gen
   import lcd_raster_pkg::*;
#(
   parameter int PIX_W   = 24,
   parameter int PATTERN = PAT_GRADIENT
) (
   input  logic [PIX_W/3-1:0] col,
   input  logic [PIX_W/3-1:0] row,
   output logic [PIX_W-1:0]   rgb
);
   localparam int CW = PIX_W / 3;

   generate
      if (PATTERN == PAT_GRADIENT) begin : g_gradient
         assign rgb = {col, row, col ^ row};
      end else begin : g_xorplane
         assign rgb = {col ^ row, col, row};
      end
   endgenerate

   if (CW < 1) begin : g_bad_cw
      $error("lcd_pattern_gen: channel width must be at least 1");
   end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
   import lcd_raster_pkg::*;
#(
   parameter int HW      = 12,
   parameter int VW      = 11,
   parameter int PIX_W   = 24,
   parameter int PATTERN = PAT_GRADIENT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [HW-1:0]    cfg_xres,
   input  logic [HW-1:0]    cfg_hbp,
   input  logic [HW-1:0]    cfg_hfp,
   input  logic [HW-1:0]    cfg_hsw,
   input  logic [VW-1:0]    cfg_yres,
   input  logic [VW-1:0]    cfg_vbp,
   input  logic [VW-1:0]    cfg_vfp,
   input  logic [VW-1:0]    cfg_vsw,
   input  logic             cfg_hpol,
   input  logic             cfg_vpol,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             line_end,
   output logic [HW-1:0]    pix_x,
   output logic [VW-1:0]    pix_y,
   output logic [PIX_W-1:0] pix_rgb
);
   localparam int CW = PIX_W / 3;

   // Elaboration-time parameter checks
   if (HW < 4) begin : g_bad_hw
      $error("lcd_raster_gen: HW must be at least 4");
   end
   if (VW < 4) begin : g_bad_vw
      $error("lcd_raster_gen: VW must be at least 4");
   end
   if (PIX_W % 3 != 0) begin : g_bad_pixw
      $error("lcd_raster_gen: PIX_W must split into three channels");
   end
   if (CW > HW || CW > VW) begin : g_bad_cw
      $error("lcd_raster_gen: channel width exceeds coordinate width");
   end
   if (PATTERN != PAT_GRADIENT && PATTERN != PAT_XORPLANE) begin : g_bad_pat
      $error("lcd_raster_gen: unknown PATTERN");
   end

   logic [HW-1:0] sh_xres, sh_hbp, sh_hfp, sh_hsw;
   logic [VW-1:0] sh_yres, sh_vbp, sh_vfp, sh_vsw;
   logic          sh_hpol, sh_vpol;

   logic [HW-1:0] h_pos, h_idx;
   logic [VW-1:0] v_pos, v_idx;
   logic          h_end, h_sync, h_act;
   logic          v_end, v_sync, v_act;
   logic          frame_wrap, de_n, last_px;
   logic [PIX_W-1:0] pat;

   assign frame_wrap = h_end & v_end;

   lcd_cfg_shadow #(.HW(HW), .VW(VW)) u_shadow (
      .clk     (clk),
      .load    (rst | frame_wrap),
      .in_xres (cfg_xres), .in_hbp (cfg_hbp), .in_hfp (cfg_hfp), .in_hsw (cfg_hsw),
      .in_yres (cfg_yres), .in_vbp (cfg_vbp), .in_vfp (cfg_vfp), .in_vsw (cfg_vsw),
      .in_hpol (cfg_hpol), .in_vpol (cfg_vpol),
      .sh_xres (sh_xres),  .sh_hbp (sh_hbp),  .sh_hfp (sh_hfp),  .sh_hsw (sh_hsw),
      .sh_yres (sh_yres),  .sh_vbp (sh_vbp),  .sh_vfp (sh_vfp),  .sh_vsw (sh_vsw),
      .sh_hpol (sh_hpol),  .sh_vpol (sh_vpol)
   );

   lcd_axis_ctr #(.W(HW)) u_hctr (
      .clk       (clk),
      .rst       (rst),
      .adv       (1'b1),
      .len_sync  (sh_hsw),
      .len_back  (sh_hbp),
      .len_act   (sh_xres),
      .len_front (sh_hfp),
      .pos       (h_pos),
      .act_idx   (h_idx),
      .at_end    (h_end),
      .in_sync   (h_sync),
      .in_act    (h_act)
   );

   lcd_axis_ctr #(.W(VW)) u_vctr (
      .clk       (clk),
      .rst       (rst),
      .adv       (h_end),
      .len_sync  (sh_vsw),
      .len_back  (sh_vbp),
      .len_act   (sh_yres),
      .len_front (sh_vfp),
      .pos       (v_pos),
      .act_idx   (v_idx),
      .at_end    (v_end),
      .in_sync   (v_sync),
      .in_act    (v_act)
   );

   lcd_pattern_gen #(.PIX_W(PIX_W), .PATTERN(PATTERN)) u_pat (
      .col (h_idx[CW-1:0]),
      .row (v_idx[CW-1:0]),
      .rgb (pat)
   );

   assign de_n    = h_act & v_act;
   assign last_px = (h_idx == sh_xres - HW'(1));

   // Single output stage: every pin changes on the same edge
   always_ff @(posedge clk) begin
      if (rst) begin
         hsync    <= ~cfg_hpol;
         vsync    <= ~cfg_vpol;
         de       <= 1'b0;
         line_end <= 1'b0;
         pix_x    <= '0;
         pix_y    <= '0;
         pix_rgb  <= '0;
      end else begin
         hsync    <= sync_level(h_sync, sh_hpol);
         vsync    <= sync_level(v_sync, sh_vpol);
         de       <= de_n;
         line_end <= de_n & last_px;
         pix_x    <= de_n ? h_idx : '0;
         pix_y    <= de_n ? v_idx : '0;
         pix_rgb  <= de_n ? pat : '0;
      end
   end
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
   parameter int HW    = 12,
   parameter int VW    = 11,
   parameter int PIX_W = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             de,
   input logic             line_end,
   input logic [HW-1:0]    pix_x,
   input logic [VW-1:0]    pix_y,
   input logic [PIX_W-1:0] pix_rgb
);
   p_rgb_blank_r8: assert property (@(posedge clk) disable iff (rst)
      !de |-> pix_rgb == '0);

   p_coord_blank_r6: assert property (@(posedge clk) disable iff (rst)
      !de |-> (pix_x == '0 && pix_y == '0));

   p_x_step_r6: assert property (@(posedge clk) disable iff (rst)
      (de && $past(de)) |-> pix_x == $past(pix_x) + HW'(1));

   p_y_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (de && $past(de)) |-> pix_y == $past(pix_y));

   p_le_in_de_r7: assert property (@(posedge clk) disable iff (rst)
      line_end |-> de);

   p_le_single_r7: assert property (@(posedge clk) disable iff (rst)
      line_end |=> !line_end);

   p_de_run_r5: assert property (@(posedge clk) disable iff (rst)
      (de && !line_end) |=> de);
endmodule

bind lcd_raster_gen lcd_raster_chk #(.HW(HW), .VW(VW), .PIX_W(PIX_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .de       (de),
   .line_end (line_end),
   .pix_x    (pix_x),
   .pix_y    (pix_y),
   .pix_rgb  (pix_rgb)
);

// File: tb/lcd_raster_gen_tb_top.sv
module lcd_raster_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] cfg_xres, cfg_hbp, cfg_hfp, cfg_hsw;
   logic [10:0] cfg_yres, cfg_vbp, cfg_vfp, cfg_vsw;
   logic        cfg_hpol, cfg_vpol;
   logic        hsync, vsync, de, line_end;
   logic [11:0] pix_x;
   logic [10:0] pix_y;
   logic [23:0] pix_rgb;

   int n_chk = 0;
   int n_err = 0;

   // Bench-side model of the scan position and the frame's settings
   int mh, mv;
   int s_xres, s_hbp, s_hfp, s_hsw, s_yres, s_vbp, s_vfp, s_vsw;
   bit s_hpol, s_vpol;

   always #4 clk = ~clk;

   lcd_raster_gen dut_i (
      .clk(clk), .rst(rst),
      .cfg_xres(cfg_xres), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp), .cfg_hsw(cfg_hsw),
      .cfg_yres(cfg_yres), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp), .cfg_vsw(cfg_vsw),
      .cfg_hpol(cfg_hpol), .cfg_vpol(cfg_vpol),
      .hsync(hsync), .vsync(vsync), .de(de), .line_end(line_end),
      .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int xr, hb, hf, hs, yr, vb, vf, vs, input bit hp, vp);
      cfg_xres = 12'(xr); cfg_hbp = 12'(hb); cfg_hfp = 12'(hf); cfg_hsw = 12'(hs);
      cfg_yres = 11'(yr); cfg_vbp = 11'(vb); cfg_vfp = 11'(vf); cfg_vsw = 11'(vs);
      cfg_hpol = hp; cfg_vpol = vp;
   endtask

   function automatic void load_model();
      s_xres = int'(cfg_xres); s_hbp = int'(cfg_hbp); s_hfp = int'(cfg_hfp); s_hsw = int'(cfg_hsw);
      s_yres = int'(cfg_yres); s_vbp = int'(cfg_vbp); s_vfp = int'(cfg_vfp); s_vsw = int'(cfg_vsw);
      s_hpol = cfg_hpol; s_vpol = cfg_vpol;
   endfunction

   // R1: reset state, then model starts at the first sync clock
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 de in reset", int'(de), 0);
      chk("R1 line_end in reset", int'(line_end), 0);
      chk("R1 pix_x in reset", int'(pix_x), 0);
      chk("R1 pix_y in reset", int'(pix_y), 0);
      chk("R1 pix_rgb in reset", int'(pix_rgb), 0);
      chk("R1 hsync idle in reset", int'(hsync), int'(!cfg_hpol));
      chk("R1 vsync idle in reset", int'(vsync), int'(!cfg_vpol));
      rst = 1'b0;
      mh = 0;
      mv = 0;
      load_model();
   endtask

   // One clock: predict outputs from the model position, advance, compare
   task automatic step(input string sc);
      int  ha_lo, va_lo, htot, vtot, ex, ey;
      bit  ha, va, ede, ele, ehs, evs;
      logic [23:0] ergb;
      logic [7:0] x8, y8;
      @(posedge clk);
      ha_lo = s_hsw + s_hbp;
      va_lo = s_vsw + s_vbp;
      htot  = ha_lo + s_xres + s_hfp;
      vtot  = va_lo + s_yres + s_vfp;
      ha  = (mh >= ha_lo) && (mh < ha_lo + s_xres);
      va  = (mv >= va_lo) && (mv < va_lo + s_yres);
      ede = ha && va;
      ex  = ede ? mh - ha_lo : 0;
      ey  = ede ? mv - va_lo : 0;
      ele = ede && (ex == s_xres - 1);
      ehs = (mh < s_hsw) ? s_hpol : !s_hpol;
      evs = (mv < s_vsw) ? s_vpol : !s_vpol;
      x8  = 8'(ex);
      y8  = 8'(ey);
      ergb = ede ? {x8, y8, x8 ^ y8} : 24'h0;
      if (mh == htot - 1) begin
         mh = 0;
         if (mv == vtot - 1) begin
            mv = 0;
            load_model();
         end else begin
            mv++;
         end
      end else begin
         mh++;
      end
      @(negedge clk);
      chk({sc, " R2/R4 hsync"}, int'(hsync), int'(ehs));
      chk({sc, " R3/R4 vsync"}, int'(vsync), int'(evs));
      chk({sc, " R5 de"}, int'(de), int'(ede));
      chk({sc, " R6 pix_x"}, int'(pix_x), ex);
      chk({sc, " R6 pix_y"}, int'(pix_y), ey);
      chk({sc, " R7 line_end"}, int'(line_end), int'(ele));
      chk({sc, " R8 pix_rgb"}, int'(pix_rgb), int'(ergb));
   endtask

   task automatic t_reset_start();
      set_cfg(8, 3, 2, 2, 4, 2, 1, 1, 1'b1, 1'b1);
      do_reset();
      step("R1 first clock");
      chk("R1 first clock hsync active", int'(hsync), 1);
      chk("R1 first clock vsync active", int'(vsync), 1);
   endtask

   task automatic t_basic();
      for (int i = 0; i < 240; i++) step("R2 R3 basic");
   endtask

   task automatic t_low_pol_zero_porch();
      set_cfg(5, 0, 0, 1, 3, 0, 0, 1, 1'b0, 1'b0);
      do_reset();
      for (int i = 0; i < 60; i++) step("R4 low polarity zero porch");
   endtask

   task automatic t_midframe_change();
      set_cfg(5, 0, 0, 1, 3, 0, 0, 1, 1'b1, 1'b1);
      do_reset();
      for (int i = 0; i < 7; i++) step("R9 before change");
      set_cfg(8, 3, 2, 2, 4, 2, 1, 1, 1'b0, 1'b1);
      for (int i = 0; i < 400; i++) step("R9 after change");
   endtask

   task automatic t_reference_line();
      int  cyc = 0;
      int  nrise = 0;
      int  rise[4];
      int  lowcnt = 0;
      bit  prev_hs = 1'b0;
      set_cfg(1024, 168, 16, 136, 2, 1, 1, 1, 1'b1, 1'b1);
      do_reset();
      for (int i = 0; i < 6000; i++) begin
         step("R10 reference");
         cyc++;
         if (hsync && !prev_hs && nrise < 4) begin
            rise[nrise] = cyc;
            nrise++;
         end
         if (nrise == 3 && !de) lowcnt++;
         prev_hs = hsync;
      end
      chk("R10 hsync rises seen", nrise, 4);
      chk("R10 hsync period", rise[1] - rise[0], 1344);
      chk("R10 de low clocks per visible line", lowcnt, 320);
   endtask

   initial begin
      #(8 * 200000);
      n_err++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      set_cfg(8, 3, 2, 2, 4, 2, 1, 1, 1'b1, 1'b1);
      t_reset_start();
      t_basic();
      t_low_pol_zero_porch();
      t_midframe_change();
      t_reference_line();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule